// File: doc/BRIEF.md
# Serial Link Power-State Sequencer

This block decides when the serial audio link runs. It produces the bit clock from a free-running local clock, and it gates the serial input data toward the controller. It also holds the power-control register. A decoded write that sets the link-stop bit does not stop the link at once. The frame in progress runs to its last bit. After that the bit clock is parked low and the returned serial data is forced to zero.

While the link is stopped, the controller wakes it by holding the frame-sync line high for a minimum time. The local clock measures that time, because no bit clock is running. Shorter pulses are ignored. Once a long enough pulse ends, the clock restarts after a short fixed delay. This warm restart clears only the link-stop bit. An asynchronous cold reset returns everything to its defaults.

Four read-only ready flags model the settling of the reference, analog, DAC and ADC sections. Each flag follows its own powerdown bit and a settle counter. All control and status pins are plain level signals; no streaming data passes through the block.

Top module: `lnk_pwr_seq`

## Requirements
- R1: While and just after cold reset (`rst_n` low, asynchronous), the register reads 0000h, `link_off_o` is 0 and the bit clock runs.
- R2: Ready flag i sits in register bit i (bits 3:0 are the reference, analog, DAC and ADC flags). It reads 1 exactly SETTLE_CYC*(i+1) clock cycles after cold reset is released or after its powerdown bit is cleared, and 0 before that.
- R3: Powerdown bit i sits in register bit 8+i. When it is set, flag i reads 0 one cycle later and stays 0 while the bit remains set.
- R4: Writes have no effect on register bits 3:0.
- R5: Writing 1 to bit 12 (link-stop) makes bit 12 read 1 on the next cycle. The bit clock keeps running until the current frame of FRAME_BITS bit-clock periods is complete. It then stays low, and `link_off_o` goes to 1. The count of bit-clock rising edges since start or restart is therefore a multiple of FRAME_BITS.
- R6: `sdin_o` follows `sdin_d_i` while the link runs and is held at 0 while `link_off_o` is 1.
- R7: Writes presented while `link_off_o` is 1 are ignored.
- R8: While the link is stopped, a sync pulse shorter than WARM_MIN clock cycles leaves the link stopped and bit 12 set.
- R9: While the link is stopped, a sync pulse of at least WARM_MIN cycles restarts the bit clock between RESTART_DLY and RESTART_DLY+6 cycles after the pulse falls. Bit 12 then reads 0, and the powerdown bits keep their values.
- R10: A cold reset while the link is stopped restores the defaults of R1 and restarts the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| wr_en_i | input | 1 | Decoded write strobe for the power-control register |
| wr_data_i | input | 16 | Write data |
| sync_i | input | 1 | Frame-sync line from the controller |
| sdin_d_i | input | 1 | Serial data toward the controller, before gating |
| bclk_o | output | 1 | Bit clock |
| sdin_o | output | 1 | Gated serial data toward the controller |
| link_off_o | output | 1 | High while the link is stopped or waking |
| rd_data_o | output | 16 | Register read value |

## Verification
The stop sequence is exercised twice: once from cold-reset alignment and once after a warm restart. This shows whether frame alignment is kept by the restart. Sync pulses are driven on both sides of the minimum width. One pulse is well below WARM_MIN and one well above, so the bench can tell a correct width filter from one that reacts to any edge. Ready flags are sampled one cycle before and at their exact settle count, both from reset and after a powerdown bit is cleared. This separates an off-by-one settle count from a correct one. Writes while the link is stopped, and writes aimed at the read-only bits, are checked against the read value to show they change nothing.

// File: rtl/lnk_pwr_pkg.sv
package lnk_pwr_pkg;
  localparam int REG_W       = 16;
  localparam int NUM_SEC     = 4;   // reference, analog, DAC, ADC
  localparam int PD_BASE     = 8;   // powerdown bits [PD_BASE +: NUM_SEC]
  localparam int LINKOFF_BIT = 12;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_OFF   = 2'd2,
    ST_WAKE  = 2'd3
  } lnk_state_e;
endpackage

// File: rtl/lnk_bitclk_gen.sv
module lnk_bitclk_gen #(
  parameter int FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic bclk_o,
  output logic frame_end_o
);
  localparam int CW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic          bclk_q;
  logic [CW-1:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      bit_q  <= '0;
    end else if (!run_i) begin
      bclk_q <= 1'b0;
      bit_q  <= '0;
    end else begin
      bclk_q <= ~bclk_q;
      if (bclk_q) bit_q <= (bit_q == LAST) ? '0 : bit_q + 1'b1;
    end
  end

  assign bclk_o      = bclk_q;
  assign frame_end_o = run_i & bclk_q & (bit_q == LAST);
endmodule

// File: rtl/lnk_warm_detect.sv
module lnk_warm_detect #(
  parameter int WARM_MIN = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic sync_i,
  output logic warm_req_o
);
  localparam int CW = $clog2(WARM_MIN + 1);
  localparam logic [CW-1:0] LIM = CW'(WARM_MIN);

  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sync_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_q <= '0;
    else if (!armed_i || !s2_q) hi_q <= '0;
    else if (hi_q != LIM)      hi_q <= hi_q + 1'b1;
  end

  assign warm_req_o = armed_i & s3_q & ~s2_q & (hi_q == LIM);
endmodule

// File: rtl/lnk_ready_track.sv
module lnk_ready_track #(
  parameter int SETTLE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIM = CW'(SETTLE);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (pd_i)         cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIM);
endmodule

// File: rtl/lnk_pwr_seq.sv
module lnk_pwr_seq
  import lnk_pwr_pkg::*;
#(
  parameter int FRAME_BITS  = 256,
  parameter int WARM_MIN    = 25,
  parameter int RESTART_DLY = 4,
  parameter int SETTLE_CYC  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             sync_i,
  input  logic             sdin_d_i,
  output logic             bclk_o,
  output logic             sdin_o,
  output logic             link_off_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int DW = $clog2(RESTART_DLY + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(RESTART_DLY - 1);

  lnk_state_e         state_q;
  logic [DW-1:0]      dly_q;
  logic [NUM_SEC-1:0] pd_q;
  logic [NUM_SEC-1:0] ready;
  logic               off_bit_q;
  logic               frame_end;
  logic               warm_req;
  logic               write_ok;
  logic               wake_done;
  logic               stopped;

  assign stopped   = (state_q == ST_OFF) || (state_q == ST_WAKE);
  assign write_ok  = wr_en_i && !stopped;
  assign wake_done = (state_q == ST_WAKE) && (dly_q == DLY_LAST);

  lnk_bitclk_gen #(.FRAME_BITS(FRAME_BITS)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (!stopped),
    .bclk_o     (bclk_o),
    .frame_end_o(frame_end)
  );

  lnk_warm_detect #(.WARM_MIN(WARM_MIN)) u_warm (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed_i   (state_q == ST_OFF),
    .sync_i    (sync_i),
    .warm_req_o(warm_req)
  );

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    lnk_ready_track #(.SETTLE(SETTLE_CYC * (g + 1))) u_rdy (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd_i   (pd_q[g]),
      .ready_o(ready[g])
    );
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      dly_q   <= '0;
    end else begin
      case (state_q)
        ST_RUN:   if (write_ok && wr_data_i[LINKOFF_BIT]) state_q <= ST_DRAIN;
        ST_DRAIN: if (frame_end) state_q <= ST_OFF;
        ST_OFF: begin
          dly_q <= '0;
          if (warm_req) state_q <= ST_WAKE;
        end
        ST_WAKE: begin
          if (wake_done) state_q <= ST_RUN;
          else           dly_q   <= dly_q + 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  // Register bits: link-stop is sticky until a restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q      <= '0;
      off_bit_q <= 1'b0;
    end else begin
      if (write_ok) begin
        pd_q      <= wr_data_i[PD_BASE +: NUM_SEC];
        off_bit_q <= off_bit_q | wr_data_i[LINKOFF_BIT];
      end else if (wake_done) begin
        off_bit_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[NUM_SEC-1:0]         = ready;
    rd_data_o[PD_BASE +: NUM_SEC]  = pd_q;
    rd_data_o[LINKOFF_BIT]         = off_bit_q;
  end

  assign link_off_o = stopped;
  assign sdin_o     = sdin_d_i & ~stopped;
endmodule

// File: rtl/lnk_pwr_seq_chk.sv
module lnk_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bclk_o,
  input logic        link_off_o,
  input logic [15:0] rd_data_o
);
  // R5
  bclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_off_o |-> !bclk_o);

  // R5
  stop_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_off_o) |-> rd_data_o[12]);

  // R9
  bit_clear_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data_o[12]) |-> $past(link_off_o));

  // R3
  pd0_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[8] |=> !rd_data_o[0]);

  // R3
  pd3_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[11] |=> !rd_data_o[3]);

  // R7
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_off_o && $past(link_off_o)) |-> $stable(rd_data_o[12:8]));
endmodule

bind lnk_pwr_seq lnk_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bclk_o    (bclk_o),
  .link_off_o(link_off_o),
  .rd_data_o (rd_data_o)
);

// File: tb/lnk_pwr_seq_bench.sv
module lnk_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FB  = 16;
  localparam int WM  = 25;
  localparam int RD  = 4;
  localparam int SC  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sync = 1'b0;
  logic        sdin_d = 1'b1;
  logic        bclk, sdin, link_off;
  logic [15:0] rd;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  int base  = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge bclk) edges <= edges + 1;

  lnk_pwr_seq #(.FRAME_BITS(FB), .WARM_MIN(WM), .RESTART_DLY(RD), .SETTLE_CYC(SC))
    u_lnk_pwr_seq (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .sync_i(sync), .sdin_d_i(sdin_d), .bclk_o(bclk), .sdin_o(sdin),
      .link_off_o(link_off), .rd_data_o(rd));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      report();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_off();
    for (int i = 0; i < 200 && !link_off; i++) @(negedge clk);
  endtask

  // R1 and R2
  task automatic t_reset_ready();
    rst_n = 1'b0;
    step(3);
    chk("R1 reg in reset", rd, 0);
    chk("R1 link_off in reset", link_off, 0);
    rst_n = 1'b1;
    base = edges;
    for (int k = 1; k <= 4*SC + 2; k++) begin
      @(negedge clk);
      for (int s = 0; s < 4; s++) begin
        if (k == SC*(s+1) - 1) chk("R2 flag before settle", rd[s], 0);
        if (k == SC*(s+1))     chk("R2 flag at settle", rd[s], 1);
      end
    end
    chk("R1 bit clock running", (edges - base) > 0, 1);
    chk("R1 link_off after reset", link_off, 0);
  endtask

  // R3 and R4
  task automatic t_powerdown();
    do_write(16'h0200);
    chk("R3 pd bit reads back", rd[9], 1);
    step(1);
    chk("R3 flag dropped", rd[1], 0);
    chk("R3 other flags stay", rd[3:0], 4'hD);
    step(10);
    chk("R3 flag held low", rd[1], 0);
    do_write(16'h0000);
    step(2*SC - 1);
    chk("R2 flag before re-settle", rd[1], 0);
    step(1);
    chk("R2 flag after re-settle", rd[1], 1);
    do_write(16'h0000);
    chk("R4 ready bits unaffected by write 0", rd, 16'h000F);
    do_write(16'h0005);
    chk("R4 ready bits unaffected by write 5", rd, 16'h000F);
  endtask

  // R5 and R6
  task automatic t_linkoff(input string tag);
    int e0;
    chk("R6 sdin passes while running", sdin, 1);
    e0 = edges;
    do_write(16'h1800);
    chk("R5 stop bit reads 1", rd[12], 1);
    wait_off();
    chk("R5 link stopped", link_off, 1);
    chk({"R5 frame aligned ", tag}, (edges - base) % FB, 0);
    chk("R5 stop within one frame", (edges - e0) <= FB + 1, 1);
    chk("R6 sdin low while off", sdin, 0);
    e0 = edges;
    step(40);
    chk("R5 bit clock stays parked", edges - e0, 0);
    chk("R5 bit clock low", bclk, 0);
  endtask

  // R7 and R8
  task automatic t_off_ignores();
    do_write(16'h0F00);
    step(2);
    chk("R7 write ignored while off", rd[15:8], 8'h18);
    @(negedge clk); sync = 1'b1;
    step(WM - 10);
    sync = 1'b0;
    step(30);
    chk("R8 short sync keeps link off", link_off, 1);
    chk("R8 short sync keeps stop bit", rd[12], 1);
  endtask

  // R9
  task automatic t_warm();
    int k;
    bit got;
    @(negedge clk); sync = 1'b1;
    step(WM + 15);
    sync = 1'b0;
    k = 0; got = 0;
    for (int i = 1; i <= 30 && !got; i++) begin
      @(negedge clk);
      if (!link_off && !bclk) base = edges;
      if (bclk) begin k = i; got = 1; end
    end
    chk("R9 restart delay in window", (k >= RD) && (k <= RD + 6), 1);
    chk("R9 stop bit cleared", rd[12], 0);
    chk("R9 pd bits kept", rd[11:8], 4'h8);
    chk("R6 sdin passes after restart", sdin, 1);
  endtask

  // R10
  task automatic t_cold();
    int e0;
    rst_n = 1'b0;
    step(2);
    chk("R10 reg cleared", rd, 0);
    rst_n = 1'b1;
    e0 = edges;
    step(10);
    chk("R10 link running", link_off, 0);
    chk("R10 bit clock restarted", (edges - e0) > 0, 1);
  endtask

  initial begin
    t_reset_ready();
    t_powerdown();
    step(7);
    t_linkoff("from reset");
    t_off_ignores();
    t_warm();
    step(23);
    t_linkoff("after warm restart");
    t_cold();
    report();
  end
endmodule